// File: doc/BRIEF.md
# Six-Pin Bidirectional Port with Pull-Up and Wake Control

The block is a six-pin general-purpose I/O port of the kind used inside a small 8-bit microcontroller. Software sees two byte-wide addresses on a simple register bus. Writes to the data address load an output latch. Writes to the direction address load a direction register, which cannot be read back. A read of the data address always returns the synchronized pin levels, whatever each pin's direction. Toward the pads the block drives an output enable, an output value and a weak pull-up request for each pin.

Configuration inputs select the pins that serve an alternate function, turn the shared weak pull-ups and the shared wake-on-change on or off, claim pin 3 as an external reset input, and give pin 2 to a timer as its clock input. Pad samples pass through a synchronizer before use. Every read of the data address stores a snapshot of the pins. The wake output then flags any wake-capable pin that has moved away from that snapshot.

Top module: `gpio_wake_port`

## Requirements
- R1: During and after reset every direction bit is 1 and the output latch is 0, so `pad_oe` is 000000 and `pad_out` is 000000.
- R2: A read with `bus_addr`=0 returns {2'b00, pins & ~cfg_alt_mask}, where pins are the `pad_in` levels delayed by two clock edges. The value does not depend on the direction bits, and bits 7:6 are always 0.
- R3: A write with `bus_addr`=0 loads `bus_wdata[5:0]` into the output latch. `pad_out` always shows the latch, and the latch keeps its value when the direction changes.
- R4: A write with `bus_addr`=1 loads the direction from `bus_wdata[5:0]`. A direction bit of 0 enables the output (`pad_oe`=1) and a bit of 1 disables it. A read with `bus_addr`=1 returns 8'h00.
- R5: Pin 3 is input-only, so `pad_oe[3]` is never 1.
- R6: A pin whose `cfg_alt_mask` bit is 1 reads as 0 in a data read.
- R7: `cfg_pullup_en`=1 sets `pad_pu` on pins 0, 1 and 3 only. Pins 2, 4 and 5 never get a pull-up.
- R8: With `cfg_xrst_en`=1, `pad_pu[3]` is 1 whatever `cfg_pullup_en` holds, and pin 3 takes no part in wake detection.
- R9: With `cfg_tmr_clk_sel`=1, `pad_oe[2]` is 0 whatever direction bit 2 holds.
- R10: A data read stores the synchronized pins as a snapshot (reset value 000000). `wake` is 1 exactly when `cfg_wake_en`=1 and at least one wake-capable pin (0, 1, and 3 unless R8 excludes it) differs from the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (a data read takes the wake snapshot) |
| bus_addr | input | 1 | 0 = data/pins, 1 = direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cfg_pullup_en | input | 1 | Shared weak pull-up enable |
| cfg_wake_en | input | 1 | Shared wake-on-change enable |
| cfg_xrst_en | input | 1 | Pin 3 serves as external reset |
| cfg_tmr_clk_sel | input | 1 | Pin 2 serves as the timer clock input |
| cfg_alt_mask | input | 6 | Pins given to alternate functions |
| pad_in | input | 6 | Pad input levels |
| pad_oe | output | 6 | Output driver enables |
| pad_out | output | 6 | Output driver values |
| pad_pu | output | 6 | Weak pull-up requests |
| wake | output | 1 | Wake-on-change indication |

## Verification
The assertions assume that the configuration inputs and `bus_addr` stay steady while a read strobe is active, and that `pad_in` is sampled only through the synchronizer. They also assume that no write strobe arrives in the same cycle as a check on latch stability. The stimulus changes inputs only on falling clock edges. It holds the configuration steady across each sweep, waits two rising edges after every pad change before it compares reads or `wake`, and raises strobes for a single cycle at a time.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int NPINS      = 6;
    localparam int REG_W      = 8;
    localparam int INONLY_IDX = 3;
    localparam int XRST_IDX   = 3;
    localparam int TMR_IDX    = 2;
    localparam logic [NPINS-1:0] PU_MASK = 6'b001011;

    typedef enum logic { A_DATA = 1'b0, A_DIR = 1'b1 } addr_e;

    typedef logic [NPINS-1:0] pinvec_t;

    typedef struct packed {
        pinvec_t latch;
        pinvec_t dir;
    } port_regs_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W  = NPINS,
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  dir_q
);
    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] dir;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (addr == A_DATA) begin
                r_d.latch = wdata[W-1:0];
            end else begin
                r_d.dir = wdata[W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.latch <= '0;
            r_q.dir   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign latch_q = r_q.latch;
    assign dir_q   = r_q.dir;
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         snap_en,
    input  logic         wake_en,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] pins,
    output logic         wake
);
    logic [W-1:0] snap_d, snap_q;
    logic [W-1:0] diff;

    always_comb begin
        snap_d = snap_q;
        if (snap_en) begin
            snap_d = pins;
        end
        diff = (pins ^ snap_q) & mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    assign wake = wake_en && (|diff);
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
    import gpio_pkg::*;
#(
    parameter int W           = NPINS,
    parameter int DW          = REG_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          cfg_pullup_en,
    input  logic          cfg_wake_en,
    input  logic          cfg_xrst_en,
    input  logic          cfg_tmr_clk_sel,
    input  logic [W-1:0]  cfg_alt_mask,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_pu,
    output logic          wake
);
    localparam int PAD_HI = DW - W;

    logic [W-1:0] pins_s;
    logic [W-1:0] latch_q, dir_q;
    logic [W-1:0] wake_mask;
    logic         data_read;

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .din (pad_in),
        .dout(pins_s)
    );

    gpio_regs #(.W(W), .DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .latch_q(latch_q),
        .dir_q  (dir_q)
    );

    assign data_read = bus_re && (bus_addr == A_DATA);

    always_comb begin
        wake_mask = PU_MASK[W-1:0];
        if (cfg_xrst_en) begin
            wake_mask[XRST_IDX] = 1'b0;
        end
    end

    gpio_wake #(.W(W)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .snap_en(data_read),
        .wake_en(cfg_wake_en),
        .mask   (wake_mask),
        .pins   (pins_s),
        .wake   (wake)
    );

    always_comb begin
        if (bus_addr == A_DATA) begin
            bus_rdata = {{PAD_HI{1'b0}}, pins_s & ~cfg_alt_mask};
        end else begin
            bus_rdata = '0;
        end
    end

    assign pad_out = latch_q;

    for (genvar i = 0; i < W; i++) begin : g_pad
        if (i == INONLY_IDX) begin : g_inonly
            assign pad_oe[i] = 1'b0;
        end else if (i == TMR_IDX) begin : g_tmr
            assign pad_oe[i] = !dir_q[i] && !cfg_tmr_clk_sel;
        end else begin : g_plain
            assign pad_oe[i] = !dir_q[i];
        end

        if (i == XRST_IDX) begin : g_pu_xrst
            assign pad_pu[i] = cfg_pullup_en || cfg_xrst_en;
        end else if (PU_MASK[i]) begin : g_pu_shared
            assign pad_pu[i] = cfg_pullup_en;
        end else begin : g_pu_none
            assign pad_pu[i] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_wake_port_chk.sv
module gpio_wake_port_chk #(
    parameter int W  = 6,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic          bus_re,
    input logic          bus_addr,
    input logic [DW-1:0] bus_rdata,
    input logic          cfg_wake_en,
    input logic          cfg_xrst_en,
    input logic          cfg_tmr_clk_sel,
    input logic [W-1:0]  cfg_alt_mask,
    input logic [W-1:0]  pins_s,
    input logic [W-1:0]  pad_oe,
    input logic [W-1:0]  pad_out,
    input logic [W-1:0]  pad_pu,
    input logic          wake
);
    a_r5_inonly: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[3]);

    a_r9_tmr_in: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tmr_clk_sel |-> !pad_oe[2]);

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DW-1:W] == '0);

    a_r4_dir_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr |-> bus_rdata == '0);

    a_r6_alt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr |-> (bus_rdata[W-1:0] & cfg_alt_mask) == '0);

    a_r8_xrst_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_xrst_en |-> pad_pu[3]);

    a_r7_no_pu_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_pu[2] && !pad_pu[4] && !pad_pu[5]);

    a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && !bus_addr) |=> $stable(pad_out));

    a_r10_wake_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wake_en |-> !wake);

    a_r10_snapshot_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !bus_addr && cfg_wake_en && $stable(cfg_xrst_en))
        |=> (!$stable(pins_s) || !wake || !$stable(cfg_xrst_en)));
endmodule

bind gpio_wake_port gpio_wake_port_chk #(.W(W), .DW(DW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_we         (bus_we),
    .bus_re         (bus_re),
    .bus_addr       (bus_addr),
    .bus_rdata      (bus_rdata),
    .cfg_wake_en    (cfg_wake_en),
    .cfg_xrst_en    (cfg_xrst_en),
    .cfg_tmr_clk_sel(cfg_tmr_clk_sel),
    .cfg_alt_mask   (cfg_alt_mask),
    .pins_s         (pins_s),
    .pad_oe         (pad_oe),
    .pad_out        (pad_out),
    .pad_pu         (pad_pu),
    .wake           (wake)
);

// File: tb/sim_gpio_wake_port.sv
`timescale 1ns/1ps
module sim_gpio_wake_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0, bus_re = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cfg_pullup_en = 1'b0, cfg_wake_en = 1'b0;
    logic       cfg_xrst_en = 1'b0, cfg_tmr_clk_sel = 1'b0;
    logic [5:0] cfg_alt_mask = '0, pad_in = '0;
    logic [5:0] pad_oe, pad_out, pad_pu;
    logic       wake;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_wake_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_pullup_en(cfg_pullup_en), .cfg_wake_en(cfg_wake_en),
        .cfg_xrst_en(cfg_xrst_en), .cfg_tmr_clk_sel(cfg_tmr_clk_sel),
        .cfg_alt_mask(cfg_alt_mask), .pad_in(pad_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu), .wake(wake)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic snap();
        @(negedge clk);
        bus_re = 1'b1; bus_addr = 1'b0;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic set_pins(input logic [5:0] p);
        @(negedge clk);
        pad_in = p;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({2'b0, pad_oe}, 8'h00, "R1 oe in reset");
        chk({2'b0, pad_out}, 8'h00, "R1 out in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk({2'b0, pad_oe}, 8'h00, "R1 oe after reset");
        chk({2'b0, pad_out}, 8'h00, "R1 out after reset");

        // R2 / R6: read sweep, all pin patterns, several alt masks and dirs
        for (int m = 0; m < 4; m++) begin
            logic [5:0] am;
            am = (m == 0) ? 6'h00 : (m == 1) ? 6'h15 : (m == 2) ? 6'h2A : 6'h3F;
            cfg_alt_mask = am;
            wr(1'b1, (m[0]) ? 8'h00 : 8'hFF);
            for (int p = 0; p < 64; p++) begin
                set_pins(p[5:0]);
                bus_addr = 1'b0;
                #0.1;
                chk(bus_rdata, {2'b00, p[5:0] & ~am}, (am == 0) ? "R2 read pins" : "R6 alt reads zero");
                bus_addr = 1'b1;
                #0.1;
                chk(bus_rdata, 8'h00, "R4 dir address reads zero");
                bus_addr = 1'b0;
            end
        end
        cfg_alt_mask = '0;

        // R2: latency of exactly two edges
        set_pins(6'h00);
        @(negedge clk); pad_in = 6'h3F;
        @(posedge clk); @(negedge clk);
        chk(bus_rdata, 8'h00, "R2 one edge not yet visible");
        @(posedge clk); @(negedge clk);
        chk(bus_rdata, 8'h3F, "R2 visible after two edges");

        // R4 / R5 / R9: direction sweep
        for (int t = 0; t < 2; t++) begin
            cfg_tmr_clk_sel = t[0];
            for (int d = 0; d < 64; d++) begin
                logic [5:0] e;
                wr(1'b1, {2'b11, d[5:0]});
                e = ~d[5:0];
                e[3] = 1'b0;
                if (t == 1) e[2] = 1'b0;
                chk({2'b0, pad_oe}, {2'b0, e}, (t == 1) ? "R9 timer pin input" : "R4 R5 direction");
            end
        end
        cfg_tmr_clk_sel = 1'b0;

        // R3: latch sweep with outputs on, then retention across direction changes
        wr(1'b1, 8'h00);
        for (int v = 0; v < 64; v++) begin
            wr(1'b0, {2'b11, v[5:0]});
            chk({2'b0, pad_out}, {2'b0, v[5:0]}, "R3 latch drives out");
        end
        wr(1'b0, 8'h2A);
        wr(1'b1, 8'hFF);
        chk({2'b0, pad_out}, 8'h2A, "R3 latch kept while input");
        chk({2'b0, pad_oe}, 8'h00, "R4 all inputs");
        wr(1'b1, 8'h00);
        chk({2'b0, pad_out}, 8'h2A, "R3 latch kept after re-enable");
        chk({2'b0, pad_oe}, 8'h37, "R5 pin3 stays off");

        // R7 / R8: pull-up combinations
        for (int c = 0; c < 4; c++) begin
            logic [5:0] e;
            cfg_pullup_en = c[0];
            cfg_xrst_en = c[1];
            @(negedge clk);
            e = c[0] ? 6'b001011 : 6'b000000;
            if (c[1]) e[3] = 1'b1;
            chk({2'b0, pad_pu}, {2'b0, e}, c[1] ? "R8 xrst pull-up" : "R7 shared pull-up");
        end
        cfg_pullup_en = 1'b0;
        cfg_xrst_en = 1'b0;

        // R10 / R8: wake against a zero snapshot
        set_pins(6'h00);
        snap();
        cfg_wake_en = 1'b1;
        for (int x = 0; x < 2; x++) begin
            cfg_xrst_en = x[0];
            for (int p = 0; p < 64; p++) begin
                logic [5:0] mk;
                set_pins(p[5:0]);
                mk = x[0] ? 6'b000011 : 6'b001011;
                chk({7'b0, wake}, {7'b0, |(p[5:0] & mk)}, x[0] ? "R8 pin3 out of wake" : "R10 wake on change");
            end
        end
        cfg_xrst_en = 1'b0;
        cfg_wake_en = 1'b0;
        #0.1;
        chk({7'b0, wake}, 8'h00, "R10 wake disabled");
        cfg_wake_en = 1'b1;
        #0.1;
        chk({7'b0, wake}, 8'h01, "R10 wake enabled again");
        snap();
        chk({7'b0, wake}, 8'h00, "R10 snapshot clears wake");
        set_pins(6'h3D);
        chk({7'b0, wake}, 8'h01, "R10 bit1 moved from snapshot");
        set_pins(6'h1F);
        chk({7'b0, wake}, 8'h00, "R10 non-wake pins ignored");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule